// File: doc/BRIEF.md
# OLED controller command decoder

This block sits behind a serial-bus slave front end that has already recovered whole bytes. For each byte it gets a one-cycle strobe with the byte value, and it also gets a one-cycle pulse at the end of each transfer. Every transfer opens with a control byte. That byte selects either a single command or a run of display data. Commands update the display configuration flags and the column and page write pointers. Display data becomes write requests into an external byte framebuffer that is 132 columns wide and 8 pages deep.

A command returns the decoder to idle, so the next byte is again read as a control byte. A small set of commands takes one argument byte, which the decoder swallows and discards. Every framebuffer write sets a sticky redraw flag. The scanout side clears that flag. Reads on the bus always return all ones.

Top module: `oled_cmd_decoder`

## Requirements
- R1: In idle mode, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte gives a one-cycle `cmd_err` pulse on the following cycle, and the decoder stays idle.
- R2: In data mode, each byte is written on the next cycle with `fb_we`=1, `fb_addr` = column + page*132 and `fb_wdata` = the byte. The column then increments by one.
- R3: When the column has reached 132, further data bytes are dropped: no write, and the column stays at 132.
- R4: Command codes 0x00 to 0x0F replace column bits [3:0] with the code's low nibble. Codes 0x10 to 0x20 replace column bits [7:4] with the code's low nibble.
- R5: Command codes 0xB0 to 0xBF set the page to bits [2:0] of the code.
- R6: Code 0xA0 clears `mirror` and 0xA1 sets it. Code 0xA4 clears `all_on` and 0xA5 sets it. Code 0xA6 clears `inverse` and 0xA7 sets it. Code 0xAE clears `disp_en` and 0xAF sets it.
- R7: Codes 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB each take the next byte as an argument. That argument is discarded with no effect and no error, and the decoder then returns to idle.
- R8: Codes 0x40 to 0x7F, 0xC0 to 0xC8 and 0xE3 change no output and raise no error. After any non-argument command, the next byte is read as a control byte.
- R9: Any other command code gives a one-cycle `cmd_err` pulse, changes no register, and returns the decoder to idle.
- R10: `xfer_end` forces the decoder to idle. A byte strobed in the same cycle as `xfer_end` is discarded.
- R11: `redraw` is set in the same cycle that `fb_we` asserts, and it stays set until `redraw_clr` is high. If a write and a clear happen in the same cycle, the write wins.
- R12: `rd_data` is always 0xFF.
- R13: After reset, the column, the page and all four flags are 0, and `redraw`, `fb_we` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| xfer_end | input | 1 | End-of-transfer pulse |
| redraw_clr | input | 1 | Clears the redraw flag |
| rd_data | output | 8 | Data returned for bus reads |
| fb_we | output | 1 | Framebuffer write request |
| fb_addr | output | 11 | Framebuffer byte address |
| fb_wdata | output | 8 | Framebuffer write data |
| redraw | output | 1 | Sticky flag: the framebuffer has changed |
| cmd_err | output | 1 | One-cycle pulse for a bad control byte or an unknown command |
| column | output | 8 | Column write pointer |
| page | output | 3 | Page write pointer |
| mirror | output | 1 | Horizontal mirror flag |
| all_on | output | 1 | Force all pixels on |
| inverse | output | 1 | Inverse video flag |
| disp_en | output | 1 | Display enable |

## Verification
The assertions assume the front end never presents a byte without its strobe. They also assume it never holds the strobe high on consecutive cycles, and that end-of-transfer is a single-cycle pulse. Under those assumptions, every write and every error pulse can be traced back to exactly one strobed byte. The bench always drives a strobe for one cycle with an idle cycle after it. It drives end-of-transfer the same way, except in one deliberate case where the strobe and end-of-transfer fall in the same cycle.

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder #(
  parameter int COLS  = 132,
  parameter int PAGES = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                byte_valid,
  input  logic [7:0]                          byte_data,
  input  logic                                xfer_end,
  input  logic                                redraw_clr,
  output logic [7:0]                          rd_data,
  output logic                                fb_we,
  output logic [$clog2(COLS*PAGES)-1:0]       fb_addr,
  output logic [7:0]                          fb_wdata,
  output logic                                redraw,
  output logic                                cmd_err,
  output logic [7:0]                          column,
  output logic [$clog2(PAGES)-1:0]            page,
  output logic                                mirror,
  output logic                                all_on,
  output logic                                inverse,
  output logic                                disp_en
);
  localparam int AW = $clog2(COLS*PAGES);
  localparam int PW = $clog2(PAGES);
  localparam logic [7:0] COL_END = 8'(COLS);

  typedef enum logic [1:0] {M_IDLE, M_DATA, M_CMD, M_ARG} mode_t;
  mode_t mode;

  logic take, wr_now;
  assign take    = byte_valid && !xfer_end;
  assign wr_now  = take && mode == M_DATA && column < COL_END;
  assign rd_data = 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_IDLE;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
      redraw   <= 1'b0;
      cmd_err  <= 1'b0;
      column   <= '0;
      page     <= '0;
      mirror   <= 1'b0;
      all_on   <= 1'b0;
      inverse  <= 1'b0;
      disp_en  <= 1'b0;
    end else begin
      fb_we   <= wr_now;
      cmd_err <= 1'b0;
      redraw  <= wr_now | (redraw & ~redraw_clr);
      if (xfer_end) begin
        mode <= M_IDLE;
      end else if (take) begin
        unique case (mode)
          M_IDLE: begin
            if (byte_data == 8'h80)      mode <= M_CMD;
            else if (byte_data == 8'h40) mode <= M_DATA;
            else                         cmd_err <= 1'b1;
          end
          M_DATA: begin
            if (wr_now) begin
              fb_addr  <= AW'(column) + AW'(page) * AW'(COLS);
              fb_wdata <= byte_data;
              column   <= column + 8'd1;
            end
          end
          M_ARG: mode <= M_IDLE;
          M_CMD: begin
            mode <= M_IDLE;
            if (byte_data <= 8'h0F)
              column[3:0] <= byte_data[3:0];
            else if (byte_data <= 8'h20)
              column[7:4] <= byte_data[3:0];
            else if (byte_data >= 8'h40 && byte_data <= 8'h7F)
              ;
            else if (byte_data >= 8'hB0 && byte_data <= 8'hBF)
              page <= PW'(byte_data[2:0]);
            else if (byte_data >= 8'hC0 && byte_data <= 8'hC8)
              ;
            else begin
              case (byte_data)
                8'hA0: mirror  <= 1'b0;
                8'hA1: mirror  <= 1'b1;
                8'hA4: all_on  <= 1'b0;
                8'hA5: all_on  <= 1'b1;
                8'hA6: inverse <= 1'b0;
                8'hA7: inverse <= 1'b1;
                8'hAE: disp_en <= 1'b0;
                8'hAF: disp_en <= 1'b1;
                8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5,
                8'hD8, 8'hD9, 8'hDA, 8'hDB: mode <= M_ARG;
                8'hE3: ;
                default: cmd_err <= 1'b1;
              endcase
            end
          end
          default: mode <= M_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/oled_cmd_decoder_chk.sv
module oled_cmd_decoder_chk #(
  parameter int AW    = 11,
  parameter int LIMIT = 1056
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_valid,
  input logic          xfer_end,
  input logic          redraw_clr,
  input logic          fb_we,
  input logic [AW-1:0] fb_addr,
  input logic          redraw,
  input logic          cmd_err
);
  // R2
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> fb_addr < AW'(LIMIT));
  // R2
  wr_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> $past(byte_valid));
  // R9
  err_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(byte_valid));
  // R1
  no_wr_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_we && cmd_err));
  // R10
  end_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> !$past(xfer_end));
  // R11
  redraw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redraw) |-> fb_we);
  // R11
  redraw_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> redraw);
  // R11
  redraw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(redraw) |-> $past(redraw_clr));
endmodule

bind oled_cmd_decoder oled_cmd_decoder_chk u_chk (.*);

// File: tb/oled_cmd_decoder_bench.sv
`timescale 1ns/1ps
module oled_cmd_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0, xfer_end = 1'b0, redraw_clr = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [7:0] rd_data, fb_wdata, column;
  logic [10:0] fb_addr;
  logic [2:0] page;
  logic fb_we, redraw, cmd_err, mirror, all_on, inverse, disp_en;

  int checks = 0, errors = 0;
  logic [18:0] sb[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  oled_cmd_decoder u_oled_cmd_decoder (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop an expected write for every write the design makes (R2, R3)
  always @(negedge clk) begin
    if (rst_n && fb_we && !done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected write", int'(fb_addr), 0);
      end else begin
        logic [18:0] e;
        e = sb.pop_front();
        check({fb_addr, fb_wdata} == e, "R2 write", int'({fb_addr, fb_wdata}), int'(e));
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    send(8'h80); send(b);
  endtask

  task automatic expect_wr(input int addr, input logic [7:0] d);
    sb.push_back({11'(addr), d});
  endtask

  task automatic end_xfer();
    @(negedge clk); xfer_end = 1'b1;
    @(negedge clk); xfer_end = 1'b0;
  endtask

  task automatic check_flags(input logic [3:0] exp, input string tag);
    check({mirror, all_on, inverse, disp_en} == exp, tag,
          int'({mirror, all_on, inverse, disp_en}), int'(exp));
  endtask

  initial begin
    #(20 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check(column == 0 && page == 0, "R13 pointers", int'({column, page}), 0);
    check_flags(4'b0000, "R13 flags");
    check(!redraw && !fb_we && !cmd_err, "R13 strobes", int'({redraw, fb_we, cmd_err}), 0);
    // R12
    check(rd_data == 8'hFF, "R12 read data", int'(rd_data), 8'hFF);

    // R5 page
    cmd(8'hB5); check(page == 3'd5, "R5 page B5", int'(page), 5);
    cmd(8'hBA); check(page == 3'd2, "R5 page BA", int'(page), 2);
    cmd(8'hB5); check(page == 3'd5, "R5 page B5 again", int'(page), 5);

    // R4 column nibbles
    cmd(8'h03); cmd(8'h12);
    check(column == 8'h23, "R4 column 0x23", int'(column), 8'h23);
    cmd(8'h20);
    check(column == 8'h03, "R4 column 0x20 high", int'(column), 8'h03);

    // R2 data writes at col 3 page 5
    send(8'h40);
    expect_wr(3 + 5 * 132, 8'hAA); send(8'hAA);
    expect_wr(4 + 5 * 132, 8'h55); send(8'h55);
    end_xfer();
    check(column == 8'd5, "R2 column increments", int'(column), 5);
    // R11 sticky redraw
    check(redraw, "R11 redraw set", int'(redraw), 1);
    repeat (3) @(negedge clk);
    check(redraw, "R11 redraw sticky", int'(redraw), 1);
    @(negedge clk); redraw_clr = 1'b1;
    @(negedge clk); redraw_clr = 1'b0;
    check(!redraw, "R11 redraw cleared", int'(redraw), 0);

    // R6 flags
    cmd(8'hA1); check_flags(4'b1000, "R6 mirror on");
    cmd(8'hA5); check_flags(4'b1100, "R6 all_on on");
    cmd(8'hA7); check_flags(4'b1110, "R6 inverse on");
    cmd(8'hAF); check_flags(4'b1111, "R6 disp_en on");
    cmd(8'hA0); check_flags(4'b0111, "R6 mirror off");
    cmd(8'hA4); check_flags(4'b0011, "R6 all_on off");
    cmd(8'hA6); check_flags(4'b0001, "R6 inverse off");

    // R7 argument bytes swallowed: 0xAE as argument must not clear disp_en
    foreach (sb[i]) ; 
    begin
      logic [7:0] argc[9] = '{8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5, 8'hD8, 8'hD9, 8'hDA, 8'hDB};
      for (int i = 0; i < 9; i++) begin
        cmd(argc[i]); send(8'hAE);
        check(disp_en && !cmd_err, $sformatf("R7 arg after 0x%0h", argc[i]),
              int'({disp_en, cmd_err}), 2);
      end
    end
    cmd(8'hA1); check_flags(4'b1001, "R7 back to idle after argument");

    // R9 unknown command
    cmd(8'hFF);
    check(cmd_err, "R9 error pulse", int'(cmd_err), 1);
    @(negedge clk);
    check(!cmd_err, "R9 pulse is one cycle", int'(cmd_err), 0);
    check(column == 5 && page == 5, "R9 pointers unchanged", int'({column, page}), (5 << 3) | 5);
    check_flags(4'b1001, "R9 flags unchanged");
    cmd(8'hA0); check_flags(4'b0001, "R9 idle after unknown");

    // R1 bad control byte, decoder stays idle
    send(8'h33);
    check(cmd_err, "R1 bad control byte", int'(cmd_err), 1);
    send(8'hA1);
    check(cmd_err && !mirror, "R1 stays idle", int'({cmd_err, mirror}), 2);

    // R8 no-effect commands
    cmd(8'h45); check(!cmd_err, "R8 start line no error", int'(cmd_err), 0);
    cmd(8'hC8); check(!cmd_err, "R8 C8 no error", int'(cmd_err), 0);
    cmd(8'hE3); check(!cmd_err, "R8 E3 no error", int'(cmd_err), 0);
    check(column == 5 && page == 5, "R8 pointers unchanged", int'({column, page}), (5 << 3) | 5);
    check_flags(4'b0001, "R8 flags unchanged");

    // R3 column end: col 131 page 0
    cmd(8'h03); cmd(8'h18); cmd(8'hB0);
    check(column == 8'd131, "R4 column 131", int'(column), 131);
    send(8'h40);
    expect_wr(131, 8'h11); send(8'h11);
    send(8'h22); send(8'h33);
    end_xfer();
    check(column == 8'd132, "R3 column holds at 132", int'(column), 132);

    // R10 byte together with end-of-transfer is discarded
    cmd(8'h00); cmd(8'h10);
    send(8'h40);
    @(negedge clk); byte_valid = 1'b1; xfer_end = 1'b1; byte_data = 8'h77;
    @(negedge clk); byte_valid = 1'b0; xfer_end = 1'b0;
    check(!fb_we && column == 0, "R10 coincident byte dropped", int'({fb_we, column}), 0);
    send(8'h77);
    check(cmd_err && !fb_we, "R10 idle after end", int'({cmd_err, fb_we}), 2);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all expected writes seen", sb.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule